// File: doc/BRIEF.md
# Partially Keyed Branch Target Buffer

This block predicts the destination of branches for a 64-bit fetch unit. The fetch stage presents a branch address on the lookup side and receives, in the same cycle, a hit flag, a full 64-bit predicted destination and a taken bit. The execute stage reports each resolved branch on the update side. The block compares the outcome with what it would have predicted, flags a misprediction, and writes the entry.

The table is direct-mapped with 256 entries. Only the low 31 address bits form the key. Address bits 9:2 select the entry and bits 30:10 are stored as a partial tag. Branches whose addresses differ only in bits 63:31 therefore share an entry. The stored destination is always kept at its full width. An elaboration option, `DOMAIN_TAG_EN`, makes the privilege domain (user or kernel) part of the key. User and kernel branches with identical low bits then occupy separate entries instead of overwriting each other.

Top module: `btb_partial`

## Requirements
- R1: After reset, and after any lookup that misses, `lk_hit`, `lk_taken` and `lk_target` are all 0.
- R2: An update writes the entry at the clock edge. A lookup of the same address in the same cycle still sees the old contents. A lookup in the following cycle hits and returns the full 64-bit `up_target`, with `lk_taken` equal to `up_taken`.
- R3: The entry is selected by `pc[9:2]` and matched against the stored `pc[30:10]`. Bits 63:31 and 1:0 take no part. A branch that differs from a trained branch only in those bits hits and receives the trained branch's destination.
- R4: A lookup whose `pc[30:10]` differs from the stored tag at the same index misses.
- R5: The prediction is "taken" only on a hit with the state bit set. `up_mispredict` is high when `up_valid` is high and either the predicted taken bit differs from `up_taken`, or both are taken and the predicted destination differs from `up_target`. With `up_valid` low, `up_mispredict` is 0.
- R6: A taken update overwrites the destination of the entry, even when that entry was trained by an aliasing branch.
- R7: A not-taken update clears the state bit. On a hit it keeps the stored destination, and later lookups report hit with `lk_taken` low. On a miss it allocates an entry holding `up_target` with the state bit clear.
- R8: With `DOMAIN_TAG_EN=1`, the domain bit (0 user, 1 kernel) is part of the key. The same low address bits in the two domains hold independent destinations. A lookup hits only the entry of its own domain.
- R9: With `DOMAIN_TAG_EN=0`, `lk_domain` and `up_domain` have no effect. An entry trained in one domain hits for a lookup in the other domain.
- R10: `flush` held for one cycle invalidates every entry at that edge. It takes priority over an update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_pc | input | 64 | Branch address to look up |
| lk_domain | input | 1 | Privilege domain of the lookup (0 user, 1 kernel) |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_target | output | 64 | Predicted destination, 0 on miss |
| lk_taken | output | 1 | Predicted taken |
| up_valid | input | 1 | A resolved branch is reported |
| up_pc | input | 64 | Address of the resolved branch |
| up_target | input | 64 | Actual destination |
| up_taken | input | 1 | Branch was actually taken |
| up_domain | input | 1 | Privilege domain of the resolved branch |
| up_mispredict | output | 1 | Prediction for the resolved branch was wrong |

## Verification
The bench trains a branch and then looks up an address that differs only above bit 30. The lookup must hit with the first destination. A design that keyed on more bits would miss there, and one that truncated the stored destination would return wrong upper bits. It then retrains through the alias and checks that the mispredict flag fires and that the original address now sees the new destination. A stale-entry bug would keep predicting the old one. It also walks the state bit through taken, not-taken and taken again, where a design that dropped the destination on a not-taken update would return a wrong address later. Further directed cases cover a same-cycle lookup of a fresh update, a flush that collides with an update, and the domain-keyed variant, where the two domains must keep separate destinations.

// File: rtl/btb_pkg.sv
// Shared types for the branch target buffer.
// Assumes a 64-bit address space for branch addresses and destinations.
package btb_pkg;
    localparam int unsigned ADDR_W = 64;

    // Result of one read port of the entry store.
    typedef struct packed {
        logic              hit;
        logic              taken;
        logic [ADDR_W-1:0] target;
    } btb_pred_t;
endpackage

// File: rtl/btb_key_split.sv
// Splits a branch address (and optionally the privilege domain) into the
// entry index and the partial tag. Only bits KEY_W-1:0 take part in the key.
// Assumes IDX_LSB >= 1 and IDX_LSB+IDX_W < KEY_W.
module btb_key_split #(
    parameter int unsigned KEY_W         = 31,
    parameter int unsigned IDX_LSB       = 2,
    parameter int unsigned IDX_W         = 8,
    parameter int unsigned DOMAIN_TAG_EN = 0,
    localparam int unsigned AW           = IDX_W + ((DOMAIN_TAG_EN != 0) ? 1 : 0),
    localparam int unsigned TAG_W        = KEY_W - IDX_LSB - IDX_W
) (
    input  logic [btb_pkg::ADDR_W-1:0] pc,
    input  logic                       domain,
    output logic [AW-1:0]              idx,
    output logic [TAG_W-1:0]           tag
);
    logic unused_key;

    // Partial tag: the key bits above the index field.
    assign tag = pc[KEY_W-1:IDX_LSB+IDX_W];

    // The index either carries the domain as its top bit or ignores it.
    if (DOMAIN_TAG_EN != 0) begin : g_dom
        assign idx        = {domain, pc[IDX_LSB +: IDX_W]};
        assign unused_key = ^{pc[btb_pkg::ADDR_W-1:KEY_W], pc[IDX_LSB-1:0]};
    end else begin : g_flat
        assign idx        = pc[IDX_LSB +: IDX_W];
        assign unused_key = ^{pc[btb_pkg::ADDR_W-1:KEY_W], pc[IDX_LSB-1:0], domain};
    end
endmodule

// File: rtl/btb_store.sv
// Direct-mapped entry store with one write port and two combinational read
// ports (fetch lookup and update-side prediction). Only valid bits are reset.
// Assumes a write and a flush in the same cycle resolve in favour of flush.
module btb_store #(
    parameter int unsigned AW    = 8,
    parameter int unsigned TAG_W = 21,
    localparam int unsigned DEPTH = 1 << AW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       we,
    input  logic [AW-1:0]              w_idx,
    input  logic [TAG_W-1:0]           w_tag,
    input  logic                       w_taken,
    input  logic [btb_pkg::ADDR_W-1:0] w_target,
    input  logic [AW-1:0]              ra_idx,
    input  logic [TAG_W-1:0]           ra_tag,
    input  logic [AW-1:0]              rb_idx,
    input  logic [TAG_W-1:0]           rb_tag,
    output btb_pkg::btb_pred_t         ra_pred,
    output btb_pkg::btb_pred_t         rb_pred
);
    logic [DEPTH-1:0]           valid_q;
    logic [TAG_W-1:0]           tag_q   [DEPTH];
    logic                       state_q [DEPTH];
    logic [btb_pkg::ADDR_W-1:0] tgt_q   [DEPTH];

    // One valid bit per entry: reset, flush, or set on a write to that slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_valid
        always_ff @(posedge clk) begin
            if (!rst_n)                           valid_q[i] <= 1'b0;
            else if (flush)                       valid_q[i] <= 1'b0;
            else if (we && (w_idx == AW'(i)))     valid_q[i] <= 1'b1;
        end
    end

    // Entry payload write; contents of invalid entries are don't-care.
    always_ff @(posedge clk) begin
        if (we) begin
            tag_q[w_idx]   <= w_tag;
            state_q[w_idx] <= w_taken;
            tgt_q[w_idx]   <= w_target;
        end
    end

    // Combinational read of one slot against a presented tag.
    function automatic btb_pkg::btb_pred_t read_slot(input logic [AW-1:0] idx,
                                                     input logic [TAG_W-1:0] tag);
        btb_pkg::btb_pred_t p;
        p.hit    = valid_q[idx] && (tag_q[idx] == tag);
        p.taken  = p.hit && state_q[idx];
        p.target = p.hit ? tgt_q[idx] : '0;
        return p;
    endfunction

    // Both read ports share the same slot decode.
    assign ra_pred = read_slot(ra_idx, ra_tag);
    assign rb_pred = read_slot(rb_idx, rb_tag);
endmodule

// File: rtl/btb_resolve.sv
// Compares a resolved branch with the current prediction for it, flags a
// misprediction and chooses the entry contents to write.
// Assumes the prediction input reflects the array before this update.
module btb_resolve (
    input  logic                       up_valid,
    input  logic                       up_taken,
    input  logic [btb_pkg::ADDR_W-1:0] up_target,
    input  btb_pkg::btb_pred_t         pred,
    output logic                       mispredict,
    output logic                       wr_taken,
    output logic [btb_pkg::ADDR_W-1:0] wr_target
);
    // Wrong direction, or right direction (taken) with a wrong destination.
    always_comb begin
        mispredict = up_valid &&
                     ((pred.taken != up_taken) ||
                      (up_taken && (pred.target != up_target)));
    end

    // Not-taken on a hit keeps the old destination; otherwise take the actual one.
    always_comb begin
        wr_taken  = up_taken;
        wr_target = (!up_taken && pred.hit) ? pred.target : up_target;
    end
endmodule

// File: rtl/btb_partial.sv
// Branch target buffer keyed on the low KEY_W address bits, storing full
// destinations. DOMAIN_TAG_EN adds the privilege domain to the key.
// Assumes one update and one lookup per cycle; lookups are combinational.
module btb_partial #(
    parameter int unsigned KEY_W         = 31,
    parameter int unsigned IDX_LSB       = 2,
    parameter int unsigned IDX_W         = 8,
    parameter int unsigned DOMAIN_TAG_EN = 0,
    localparam int unsigned AW           = IDX_W + ((DOMAIN_TAG_EN != 0) ? 1 : 0),
    localparam int unsigned TAG_W        = KEY_W - IDX_LSB - IDX_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic [63:0] lk_pc,
    input  logic        lk_domain,
    output logic        lk_hit,
    output logic [63:0] lk_target,
    output logic        lk_taken,
    input  logic        up_valid,
    input  logic [63:0] up_pc,
    input  logic [63:0] up_target,
    input  logic        up_taken,
    input  logic        up_domain,
    output logic        up_mispredict
);
    logic [AW-1:0]      lk_idx, up_idx;
    logic [TAG_W-1:0]   lk_tag, up_tag;
    btb_pkg::btb_pred_t lk_pred, up_pred;
    logic               wr_taken;
    logic [63:0]        wr_target;

    btb_key_split #(.KEY_W(KEY_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W),
                    .DOMAIN_TAG_EN(DOMAIN_TAG_EN)) u_lk_key (
        .pc(lk_pc), .domain(lk_domain), .idx(lk_idx), .tag(lk_tag));

    btb_key_split #(.KEY_W(KEY_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W),
                    .DOMAIN_TAG_EN(DOMAIN_TAG_EN)) u_up_key (
        .pc(up_pc), .domain(up_domain), .idx(up_idx), .tag(up_tag));

    btb_store #(.AW(AW), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .we(up_valid), .w_idx(up_idx), .w_tag(up_tag),
        .w_taken(wr_taken), .w_target(wr_target),
        .ra_idx(lk_idx), .ra_tag(lk_tag),
        .rb_idx(up_idx), .rb_tag(up_tag),
        .ra_pred(lk_pred), .rb_pred(up_pred));

    btb_resolve u_resolve (
        .up_valid(up_valid), .up_taken(up_taken), .up_target(up_target),
        .pred(up_pred), .mispredict(up_mispredict),
        .wr_taken(wr_taken), .wr_target(wr_target));

    // Drive the lookup outputs from the fetch-side read port.
    assign lk_hit    = lk_pred.hit;
    assign lk_taken  = lk_pred.taken;
    assign lk_target = lk_pred.target;
endmodule

// File: rtl/btb_partial_chk.sv
// Temporal checks on the branch target buffer ports, bound to every instance.
// Assumes clk and the synchronous active-low rst_n of the bound instance.
module btb_partial_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        flush,
    input logic [63:0] lk_pc,
    input logic        lk_domain,
    input logic        lk_hit,
    input logic [63:0] lk_target,
    input logic        lk_taken,
    input logic        up_valid,
    input logic [63:0] up_pc,
    input logic [63:0] up_target,
    input logic        up_taken,
    input logic        up_domain,
    input logic        up_mispredict
);
    // R1: a miss never predicts taken and never returns a destination.
    a_r1_miss_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (!lk_taken && lk_target == 64'd0));

    // R10: after a flush nothing hits.
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    // R2: a taken update is visible to a lookup of the same branch next cycle.
    a_r2_update_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !flush && up_taken) |=>
            (!(lk_pc == $past(up_pc) && lk_domain == $past(up_domain)) ||
             (lk_hit && lk_taken && lk_target == $past(up_target))));

    // R7: a not-taken update leaves a hitting entry predicting not taken.
    a_r7_not_taken_state: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !flush && !up_taken) |=>
            (!(lk_pc == $past(up_pc) && lk_domain == $past(up_domain)) ||
             (lk_hit && !lk_taken)));

    // R5: no misprediction without a resolved branch.
    a_r5_misp_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |-> !up_mispredict);
endmodule

bind btb_partial btb_partial_chk u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_pc(lk_pc), .lk_domain(lk_domain), .lk_hit(lk_hit),
    .lk_target(lk_target), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_target(up_target),
    .up_taken(up_taken), .up_domain(up_domain), .up_mispredict(up_mispredict));

// File: tb/tb_btb_partial.sv
// Self-checking bench: a vector table on the flat-keyed instance, then
// directed tests for reset, same-cycle visibility, flush and the domain key.
module tb_btb_partial;
    localparam logic [63:0] PA = 64'h0000_0011_0000_2220;
    localparam logic [63:0] PB = 64'h0000_0022_0000_2220;
    localparam logic [63:0] PC = 64'h0000_0011_0000_2620;
    localparam logic [63:0] PD = 64'h0000_0000_8000_0040;
    localparam logic [63:0] PE = 64'h0000_0000_0000_0100;
    localparam logic [63:0] PF = 64'h0000_0000_0000_0200;
    localparam logic [63:0] TA = 64'h0000_0011_0000_4440;
    localparam logic [63:0] TB = 64'h0000_0022_0000_4440;
    localparam logic [63:0] TD = 64'hFFFF_FFFF_ABC0_0000;
    localparam logic [63:0] TE = 64'h0000_0000_0000_1234;
    localparam logic [63:0] TF = 64'h0000_0000_0000_5555;
    localparam logic [63:0] TX = 64'h0000_0000_0000_9990;

    typedef struct packed {
        logic        upd;
        logic [63:0] u_pc;
        logic [63:0] u_tgt;
        logic        u_tk;
        logic        u_dom;
        logic        e_misp;
        logic [63:0] l_pc;
        logic        e_hit;
        logic [63:0] e_tgt;
        logic        e_tk;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, PA, TA, 1'b1, 1'b0, 1'b1, PA, 1'b1, TA, 1'b1},       // R2 train, R5 miss->taken
        '{1'b0, 64'd0, 64'd0, 1'b0, 1'b0, 1'b0, PB, 1'b1, TA, 1'b1}, // R3 alias above bit 30
        '{1'b1, PB, TB, 1'b1, 1'b0, 1'b1, PB, 1'b1, TB, 1'b1},       // R6 wrong target via alias
        '{1'b0, 64'd0, 64'd0, 1'b0, 1'b0, 1'b0, PA, 1'b1, TB, 1'b1}, // R6 original sees new target
        '{1'b0, 64'd0, 64'd0, 1'b0, 1'b0, 1'b0, PA | 64'd3, 1'b1, TB, 1'b1}, // R3 low bits ignored
        '{1'b0, 64'd0, 64'd0, 1'b0, 1'b0, 1'b0, PC, 1'b0, 64'd0, 1'b0},      // R4 tag bit 10 differs
        '{1'b1, PB, TB, 1'b1, 1'b0, 1'b0, PB, 1'b1, TB, 1'b1},       // R5 correct prediction
        '{1'b1, PB, TX, 1'b0, 1'b0, 1'b1, PB, 1'b1, TB, 1'b0},       // R7 not-taken keeps target
        '{1'b1, PB, TX, 1'b0, 1'b0, 1'b0, PB, 1'b1, TB, 1'b0},       // R5 correct not-taken
        '{1'b1, PB, TB, 1'b1, 1'b0, 1'b1, PB, 1'b1, TB, 1'b1},       // R5 direction wrong
        '{1'b1, PD, TD, 1'b1, 1'b1, 1'b1, 64'h40, 1'b1, TD, 1'b1},   // R9 domain ignored
        '{1'b1, PE, TE, 1'b0, 1'b0, 1'b0, PE, 1'b1, TE, 1'b0}        // R7 not-taken allocate
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic [63:0] lk_pc = '0, up_pc = '0, up_target = '0;
    logic lk_domain = 1'b0, up_valid = 1'b0, up_taken = 1'b0, up_domain = 1'b0;
    logic lk_hit, lk_taken, up_mispredict;
    logic [63:0] lk_target;

    logic [63:0] t_lk_pc = '0, t_up_pc = '0, t_up_target = '0;
    logic t_lk_domain = 1'b0, t_up_valid = 1'b0, t_up_taken = 1'b0, t_up_domain = 1'b0;
    logic t_hit, t_taken, t_misp;
    logic [63:0] t_target;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    btb_partial #(.DOMAIN_TAG_EN(0)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_pc(lk_pc), .lk_domain(lk_domain), .lk_hit(lk_hit),
        .lk_target(lk_target), .lk_taken(lk_taken),
        .up_valid(up_valid), .up_pc(up_pc), .up_target(up_target),
        .up_taken(up_taken), .up_domain(up_domain), .up_mispredict(up_mispredict));

    btb_partial #(.DOMAIN_TAG_EN(1)) dut_tag (
        .clk(clk), .rst_n(rst_n), .flush(1'b0),
        .lk_pc(t_lk_pc), .lk_domain(t_lk_domain), .lk_hit(t_hit),
        .lk_target(t_target), .lk_taken(t_taken),
        .up_valid(t_up_valid), .up_pc(t_up_pc), .up_target(t_up_target),
        .up_taken(t_up_taken), .up_domain(t_up_domain), .up_mispredict(t_misp));

    task automatic check(input string req, input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Lookup on the flat-keyed instance; result compared as {hit,taken,target}.
    task automatic look(input string req, input logic [63:0] pc, input logic dom,
                        input logic eh, input logic [63:0] et, input logic ek);
        @(negedge clk);
        up_valid = 1'b0; lk_pc = pc; lk_domain = dom;
        #1 check(req, {lk_hit, lk_taken, lk_target}, {eh, ek, et});
    endtask

    task automatic t_update(input string req, input logic [63:0] pc, input logic [63:0] tg,
                            input logic dom, input logic em);
        @(negedge clk);
        t_up_valid = 1'b1; t_up_pc = pc; t_up_target = tg; t_up_taken = 1'b1; t_up_domain = dom;
        #1 check(req, {65'd0, t_misp}, {65'd0, em});
        @(posedge clk);
        #1 t_up_valid = 1'b0;
    endtask

    task automatic t_look(input string req, input logic [63:0] pc, input logic dom,
                          input logic eh, input logic [63:0] et, input logic ek);
        @(negedge clk);
        t_lk_pc = pc; t_lk_domain = dom;
        #1 check(req, {t_hit, t_taken, t_target}, {eh, ek, et});
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty after reset on both variants.
        look("R1 reset", PA, 1'b0, 1'b0, 64'd0, 1'b0);
        t_look("R1 reset tagged", PA, 1'b0, 1'b0, 64'd0, 1'b0);

        // Vector table on the flat-keyed instance.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            up_valid = VECS[i].upd; up_pc = VECS[i].u_pc; up_target = VECS[i].u_tgt;
            up_taken = VECS[i].u_tk; up_domain = VECS[i].u_dom;
            #1 check($sformatf("vector %0d mispredict", i), {65'd0, up_mispredict},
                     {65'd0, VECS[i].e_misp});
            look($sformatf("vector %0d lookup", i), VECS[i].l_pc, 1'b0,
                 VECS[i].e_hit, VECS[i].e_tgt, VECS[i].e_tk);
        end

        // R2: same-cycle lookup sees old contents, next cycle sees the update.
        @(negedge clk);
        up_valid = 1'b1; up_pc = PF; up_target = TF; up_taken = 1'b1; up_domain = 1'b0;
        lk_pc = PF; lk_domain = 1'b0;
        #1 check("R2 same cycle", {lk_hit, lk_taken, lk_target}, {1'b0, 1'b0, 64'd0});
        look("R2 next cycle", PF, 1'b0, 1'b1, TF, 1'b1);

        // R10: flush colliding with an update leaves everything empty.
        @(negedge clk);
        flush = 1'b1; up_valid = 1'b1; up_pc = PE; up_target = TE; up_taken = 1'b1;
        @(negedge clk);
        flush = 1'b0; up_valid = 1'b0;
        look("R10 flush entry A", PA, 1'b0, 1'b0, 64'd0, 1'b0);
        look("R10 flush beats update", PE, 1'b0, 1'b0, 64'd0, 1'b0);
        look("R10 flush entry D", 64'h40, 1'b0, 1'b0, 64'd0, 1'b0);

        // R8: domain-keyed instance keeps user and kernel entries apart.
        t_update("R8 user train", PA, TA, 1'b0, 1'b1);
        t_update("R8 kernel train is a miss", PB, TB, 1'b1, 1'b1);
        t_look("R8 user entry", PA, 1'b0, 1'b1, TA, 1'b1);
        t_look("R8 kernel entry", PB, 1'b1, 1'b1, TB, 1'b1);
        t_look("R8 user alias", PB, 1'b0, 1'b1, TA, 1'b1);
        t_look("R8 kernel alias", PA, 1'b1, 1'b1, TB, 1'b1);
        t_update("R8 user retrain correct", PA, TA, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule